// File: doc/BRIEF.md
# Correlator Result Packet Framer

This block sits between the correlator's result stream and a 10 GbE byte-wide transmit path. A packet's payload arrives as a byte stream. The block first sends a fixed 40-byte header and then passes the payload through unchanged. The header describes where the data belongs:
- the packet's position inside its accumulation;
- a running accumulation count;
- an accumulation index that stays locked to a once-per-second timing pulse;
- the configuration that was in force: delay words, FFT shift, ADC overflow count, board number, and either the source antenna and polarization or the antenna pair of a baseline.

The payload source marks the final byte of each packet with `s_tlast`. It raises `s_tacc` with that byte when the packet closes an accumulation. Packets can be any length, so the closing packet of an accumulation may be short. The block keeps the packet number, the global accumulation count and the per-second index itself, and it copies all configuration inputs into the header when a packet starts.

Top module: `corr_pkt_framer`

## Requirements
- R1: After reset, `m_tvalid`, `m_tlast` and `s_tready` are low. The first packet's header carries packet number 0, global accumulation count 0 and index 0.
- R2: Every packet on the output is exactly 40 header bytes followed by the payload bytes. Header byte 0 holds the value 40. `m_tlast` is high only on the final payload byte.
- R3: Header layout, with every multi-byte field sent most significant byte first:
  - offset 0: header length;
  - offset 1: type;
  - offset 2: board number;
  - offsets 3 and 4: identity A and identity B;
  - offset 5: packet number;
  - offsets 6-7: accumulation length;
  - offsets 8-11: global accumulation count;
  - offsets 12-15: per-second index;
  - offsets 16-19: FFT shift;
  - offsets 20-23: ADC overflow count;
  - offsets 24-39: delay words 0, 1, 2 and 3, four bytes each.
- R4: The type byte is 0x01 for correlation data and 0x00 for power data. Identity A is `cfg_ant0`. Identity B is `cfg_ant1` for correlation data. For power data it is the polarization code, zero-extended, with X=0, Y=1, R=2 and L=3.
- R5: The packet number rises by one per packet and wraps from 255 to 0. After a packet flagged as closing an accumulation, it returns to 0.
- R6: The global accumulation count rises by one after every closing packet. No other event changes it, including the timing pulse.
- R7: The per-second index advances by one after every closing packet and wraps from SEC_MOD-1 to 0.
- R8: A `pps` pulse is held until the next closing packet ends. At that point the index becomes 0 instead of advancing. Packets sent before that point still carry the old index.
- R9: The header carries the configuration values present in the cycle the packet started. Changes made while the packet is being sent do not alter it.
- R10: While `m_tready` is low, header bytes are held and not skipped. `s_tready` is high only during payload and only while `m_tready` is high.
- R11: Payload bytes pass through in order and unchanged, for any length from one byte up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_acc_len | input | 16 | Frames per accumulation |
| cfg_delay0 | input | 32 | Delay word, input 0 |
| cfg_delay1 | input | 32 | Delay word, input 1 |
| cfg_delay2 | input | 32 | Delay word, input 2 |
| cfg_delay3 | input | 32 | Delay word, input 3 |
| cfg_fft_shift | input | 32 | FFT shift setting |
| cfg_adc_ovf | input | 32 | ADC overflow count |
| cfg_board | input | 8 | Board / engine number |
| cfg_is_corr | input | 1 | 1 = correlation payload, 0 = power payload |
| cfg_ant0 | input | 8 | First antenna number |
| cfg_ant1 | input | 8 | Second antenna number (correlation) |
| cfg_pol | input | 2 | Polarization code for power packets |
| pps | input | 1 | One-cycle once-per-second pulse |
| s_tdata | input | 8 | Payload byte |
| s_tvalid | input | 1 | Payload byte valid |
| s_tlast | input | 1 | Final payload byte of packet |
| s_tacc | input | 1 | Packet closes an accumulation (with s_tlast) |
| s_tready | output | 1 | Payload byte accepted |
| m_tdata | output | 8 | Output byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Final byte of packet |
| m_tready | input | 1 | Downstream ready |

## Verification
The bench builds the block with SEC_MOD set to 5. With that value, a few closing packets carry the per-second index through its wrap, and a timing pulse can be shown to force a nonzero index back to 0. The packet-number wrap is the same 8-bit wrap at any parameter value. It is reached by a run of 257 one-byte packets with no closing flag.

// File: rtl/corr_pkt_framer.sv
module corr_pkt_framer #(
  parameter int SEC_MOD = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_acc_len,
  input  logic [31:0] cfg_delay0,
  input  logic [31:0] cfg_delay1,
  input  logic [31:0] cfg_delay2,
  input  logic [31:0] cfg_delay3,
  input  logic [31:0] cfg_fft_shift,
  input  logic [31:0] cfg_adc_ovf,
  input  logic [7:0]  cfg_board,
  input  logic        cfg_is_corr,
  input  logic [7:0]  cfg_ant0,
  input  logic [7:0]  cfg_ant1,
  input  logic [1:0]  cfg_pol,
  input  logic        pps,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  input  logic        s_tlast,
  input  logic        s_tacc,
  output logic        s_tready,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  output logic        m_tlast,
  input  logic        m_tready
);
  localparam int HDR_BYTES = 40;
  localparam int HDR_BITS  = HDR_BYTES * 8;
  localparam int SEC_W     = (SEC_MOD > 1) ? $clog2(SEC_MOD) : 1;
  localparam int HIDX_W    = $clog2(HDR_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY} st_t;

  st_t                 st;
  logic [HIDX_W-1:0]   hidx;
  logic [HDR_BITS-1:0] hdr_q;
  logic [7:0]          pkt_num;
  logic [31:0]         acc_num;
  logic [SEC_W-1:0]    sec_idx;
  logic                pps_pend;

  wire [7:0]  id_b     = cfg_is_corr ? cfg_ant1 : {6'd0, cfg_pol};
  wire [31:0] sec_word = 32'(sec_idx);
  wire [HDR_BITS-1:0] hdr_d = {
    8'(HDR_BYTES), 7'd0, cfg_is_corr, cfg_board, cfg_ant0, id_b, pkt_num,
    cfg_acc_len, acc_num, sec_word, cfg_fft_shift, cfg_adc_ovf,
    cfg_delay0, cfg_delay1, cfg_delay2, cfg_delay3};

  wire hdr_beat = (st == S_HDR) && m_tready;
  wire pkt_done = (st == S_PAY) && s_tvalid && m_tready && s_tlast;
  wire acc_bnd  = pkt_done && s_tacc;
  wire [SEC_W-1:0] sec_adv = (sec_idx == SEC_W'(SEC_MOD - 1)) ? '0 : sec_idx + 1'b1;

  assign m_tvalid = (st == S_HDR) || ((st == S_PAY) && s_tvalid);
  assign m_tdata  = (st == S_HDR) ? hdr_q[HDR_BITS-1 -: 8] : s_tdata;
  assign m_tlast  = (st == S_PAY) && s_tlast;
  assign s_tready = (st == S_PAY) && m_tready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      hidx  <= '0;
      hdr_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (s_tvalid) begin
          hdr_q <= hdr_d;
          hidx  <= '0;
          st    <= S_HDR;
        end
        S_HDR: if (hdr_beat) begin
          hdr_q <= {hdr_q[HDR_BITS-9:0], 8'd0};
          hidx  <= hidx + 1'b1;
          if (hidx == HIDX_W'(HDR_BYTES - 1)) st <= S_PAY;
        end
        S_PAY: if (pkt_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_num  <= '0;
      acc_num  <= '0;
      sec_idx  <= '0;
      pps_pend <= 1'b0;
    end else begin
      if (acc_bnd) begin
        pkt_num  <= '0;
        acc_num  <= acc_num + 1'b1;
        sec_idx  <= (pps_pend || pps) ? '0 : sec_adv;
        pps_pend <= 1'b0;
      end else begin
        if (pkt_done) pkt_num <= pkt_num + 1'b1;
        if (pps) pps_pend <= 1'b1;
      end
    end
  end

  // R2
  hdr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && s_tvalid) |=> (m_tvalid && m_tdata == 8'(HDR_BYTES)));

  // R10
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && !m_tready) |=> (st == S_HDR && $stable(m_tdata) && !s_tready));

  // R6
  acc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_bnd |=> $stable(acc_num));

  // R8
  pps_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bnd && pps_pend) |=> (sec_idx == '0));

  // R7
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sec_idx) < 32'(SEC_MOD));

  // R5
  pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !s_tacc) |=> (pkt_num == $past(pkt_num) + 8'd1));
endmodule

// File: tb/corr_pkt_framer_bench.sv
module corr_pkt_framer_bench;
  localparam int SM = 5;
  localparam int NV = 8;
  // {len[7:0], acc_end, is_corr, pol[1:0], backpressure}
  localparam logic [12:0] VEC [NV] = '{
    {8'd10, 1'b0, 1'b0, 2'd0, 1'b0},
    {8'd3,  1'b0, 1'b1, 2'd1, 1'b1},
    {8'd1,  1'b1, 1'b0, 2'd2, 1'b0},
    {8'd20, 1'b0, 1'b0, 2'd3, 1'b1},
    {8'd6,  1'b1, 1'b1, 2'd0, 1'b0},
    {8'd2,  1'b1, 1'b0, 2'd1, 1'b1},
    {8'd5,  1'b1, 1'b1, 2'd2, 1'b0},
    {8'd1,  1'b1, 1'b0, 2'd3, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cfg_acc_len = 16'd2930;
  logic [31:0] cfg_delay0 = 32'h0102_0304, cfg_delay1 = 32'h1122_3344;
  logic [31:0] cfg_delay2 = 32'h5566_7788, cfg_delay3 = 32'h99AA_BBCC;
  logic [31:0] cfg_fft_shift = 32'h0000_0FF5, cfg_adc_ovf = 32'hDEAD_0007;
  logic [7:0]  cfg_board = 8'h03, cfg_ant0 = 8'h0C, cfg_ant1 = 8'h0E;
  logic        cfg_is_corr = 1'b0;
  logic [1:0]  cfg_pol = 2'd0;
  logic pps = 1'b0, s_tvalid = 1'b0, s_tlast = 1'b0, s_tacc = 1'b0, m_tready = 1'b1;
  logic [7:0] s_tdata = 8'd0;
  logic s_tready, m_tvalid, m_tlast;
  logic [7:0] m_tdata;

  int checks = 0, fails = 0;
  int m_pkt = 0, m_acc = 0, m_sec = 0;
  bit m_pend = 1'b0;
  logic [7:0] rx [300];
  logic       rx_last [300];
  int rx_n = 0;

  always #5 clk = ~clk;

  corr_pkt_framer #(.SEC_MOD(SM)) u_corr_pkt_framer (
    .clk(clk), .rst_n(rst_n), .cfg_acc_len(cfg_acc_len),
    .cfg_delay0(cfg_delay0), .cfg_delay1(cfg_delay1), .cfg_delay2(cfg_delay2),
    .cfg_delay3(cfg_delay3), .cfg_fft_shift(cfg_fft_shift), .cfg_adc_ovf(cfg_adc_ovf),
    .cfg_board(cfg_board), .cfg_is_corr(cfg_is_corr), .cfg_ant0(cfg_ant0),
    .cfg_ant1(cfg_ant1), .cfg_pol(cfg_pol), .pps(pps), .s_tdata(s_tdata),
    .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tacc(s_tacc), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp,
                     input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fld(input int off, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[23:0], rx[off+i]};
    return v;
  endfunction

  task automatic pulse_pps();
    @(negedge clk); pps = 1'b1;
    @(negedge clk); pps = 1'b0;
    m_pend = 1'b1;
  endtask

  task automatic send_pkt(input int len, input bit aend, input bit disturb, input bit bp,
                          input string sec_tag);
    logic [319:0] eh;
    logic [7:0] base;
    int si = 0, guard = 0, mis = 0, pmis = 0, lastcnt = 0;
    bit done = 1'b0, badr = 1'b0, hit = 1'b0;
    base = 8'(len * 7 + m_pkt);
    eh = {8'd40, 7'd0, cfg_is_corr, cfg_board, cfg_ant0,
          (cfg_is_corr ? cfg_ant1 : {6'd0, cfg_pol}), 8'(m_pkt), cfg_acc_len,
          32'(m_acc), 32'(m_sec), cfg_fft_shift, cfg_adc_ovf,
          cfg_delay0, cfg_delay1, cfg_delay2, cfg_delay3};
    rx_n = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
      s_tvalid = (si < len);
      s_tdata  = base + 8'(si);
      s_tlast  = (si == len - 1);
      s_tacc   = aend;
      m_tready = bp ? (guard % 3 != 0) : 1'b1;
      if (disturb && !hit && rx_n == 3) begin
        hit = 1'b1;
        cfg_fft_shift = ~cfg_fft_shift;
        cfg_board     = cfg_board + 8'd1;
        cfg_delay2    = cfg_delay2 ^ 32'h0000_FFFF;
        cfg_acc_len   = cfg_acc_len + 16'd1;
      end
      #1;
      if (s_tready && !m_tready) badr = 1'b1;
      if (s_tvalid && s_tready) si++;
      if (m_tvalid && m_tready && rx_n < 300) begin
        rx[rx_n] = m_tdata;
        rx_last[rx_n] = m_tlast;
        rx_n++;
        if (m_tlast) done = 1'b1;
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0; s_tacc = 1'b0; m_tready = 1'b1;
    chk(done, "R2", done, 1, "packet completed");
    chk(rx_n == 40 + len, "R2", rx_n, 40 + len, "byte count");
    chk(rx[0] == 8'd40, "R2", rx[0], 40, "header length byte");
    for (int i = 0; i < 40; i++) if (rx[i] !== eh[319-8*i -: 8]) mis++;
    chk(mis == 0, disturb ? "R9" : "R3", mis, 0, "header byte mismatches");
    chk(rx[1] == eh[311:304] && rx[4] == eh[287:280], "R4", {rx[1], rx[4]},
        {eh[311:304], eh[287:280]}, "type and identity B");
    chk(rx[5] == 8'(m_pkt), "R5", rx[5], m_pkt, "packet number");
    chk(fld(8, 4) == 32'(m_acc), "R6", fld(8, 4), m_acc, "global accumulation");
    chk(fld(12, 4) == 32'(m_sec), sec_tag, fld(12, 4), m_sec, "per-second index");
    for (int i = 0; i < len && 40 + i < rx_n; i++) if (rx[40+i] !== base + 8'(i)) pmis++;
    chk(pmis == 0, "R11", pmis, 0, "payload mismatches");
    for (int i = 0; i < rx_n; i++) if (rx_last[i]) lastcnt++;
    chk(lastcnt == 1 && rx_last[rx_n-1], "R2", lastcnt, 1, "last markers");
    chk(!badr, "R10", badr, 0, "ready without downstream ready");
    if (aend) begin
      m_acc++;
      m_sec  = m_pend ? 0 : (m_sec + 1) % SM;
      m_pend = 1'b0;
      m_pkt  = 0;
    end else begin
      m_pkt = (m_pkt + 1) % 256;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!m_tvalid && !s_tready && !m_tlast, "R1", {m_tvalid, s_tready, m_tlast}, 0,
        "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!m_tvalid && !s_tready, "R1", {m_tvalid, s_tready}, 0, "idle after reset");

    // R1 first packet counters zero; R7 wraps through SM boundaries
    for (int v = 0; v < NV; v++) begin
      cfg_is_corr = VEC[v][3];
      cfg_pol     = VEC[v][2:1];
      cfg_ant1    = 8'h0E + 8'(v);
      send_pkt(int'(VEC[v][12:5]), VEC[v][4], 1'b0, VEC[v][0], (v == 0) ? "R1" : "R7");
    end

    // R8: pulse held until the next closing packet
    send_pkt(4, 1'b1, 1'b0, 1'b0, "R7");
    send_pkt(4, 1'b1, 1'b0, 1'b0, "R7");
    pulse_pps();
    send_pkt(3, 1'b0, 1'b0, 1'b0, "R8");
    send_pkt(2, 1'b1, 1'b0, 1'b0, "R8");
    send_pkt(2, 1'b0, 1'b0, 1'b1, "R8");
    // R8: pulse during a closing packet's own boundary via idle pulse then two boundaries
    pulse_pps();
    send_pkt(1, 1'b1, 1'b0, 1'b0, "R8");
    send_pkt(1, 1'b1, 1'b0, 1'b0, "R8");

    // R9: configuration changed mid-packet
    send_pkt(8, 1'b0, 1'b1, 1'b1, "R7");
    send_pkt(3, 1'b0, 1'b0, 1'b0, "R7");

    // R5: packet number wrap over 257 packets
    send_pkt(1, 1'b1, 1'b0, 1'b0, "R7");
    for (int k = 0; k < 257; k++) send_pkt(1, 1'b0, 1'b0, 1'b0, "R7");
    chk(m_pkt == 1, "R5", m_pkt, 1, "model wrapped");
    send_pkt(5, 1'b1, 1'b0, 1'b1, "R7");
    send_pkt(1, 1'b0, 1'b0, 1'b0, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule